// File: doc/BRIEF.md
# Two-Level Character-Cell Video Generator

This block produces a 640x480 raster with its syncs and fills a centred 512x256 window with text or block graphics. Everything outside the window is black. The window is a grid of 32 columns by 32 rows of cells. Each cell is 16 pixels wide and 8 lines high. For each cell the block looks up a 16-bit descriptor in a cell table held at the bottom of word memory. The descriptor holds a 10-bit glyph number and two 3-bit colours, one for set bits and one for clear bits. The block then reads one 16-bit line of that glyph from a glyph store that begins at word 0xE000. That word is shifted out left to right, one bit per pixel, and each bit picks one of the two colours.

Memory is reached through a byte-wide read port. Each 16-bit word costs two requests: the low byte first, then the high byte. The read data must arrive on the clock after each request and stay there until the next request. Pixel timing comes from an 11-bit phase accumulator. Its carry is the pixel enable, so the pixel rate is the clock rate times the increment divided by 2048. The default increment of 776 gives close to 25 MHz from 66 MHz.

The next cell is fetched while the current cell's 16 pixels are being shown, so cells follow one another with no gap. The raster geometry, the grid size and the accumulator increment are all parameters.

Top module: `cellvid_gen`

## Requirements
- R1: While reset is asserted, `pix_tick` and `mem_rd` are 0, `pix_rgb` is 0 and both sync outputs are 1.
- R2: The pixel enable fires exactly `PHASE_INC` times in any 2048 consecutive clocks. Each enable produces one new pixel, marked by a one-clock `pix_tick` pulse.
- R3: Pixel columns count from 0 (the first visible pixel) to the line total minus 1. `hsync_n` is 0 exactly for columns H_VIS+H_FP up to, but not including, H_VIS+H_FP+H_SYNC.
- R4: Lines count from 0 (the first visible line) to the frame total minus 1. `vsync_n` is 0 exactly for lines V_VIS+V_FP up to, but not including, V_VIS+V_FP+V_SYNC.
- R5: Any pixel outside the centred window is 0 on `pix_rgb`. The horizontal border is (H_VIS-16*COLS)/2 and the vertical border is (V_VIS-8*ROWS)/2.
- R6: Inside the window, pixel x of cell line y shows bit 15-(x mod 16) of the glyph word. A 1 selects descriptor bits 15:13 and a 0 selects bits 12:10, driven unchanged on `pix_rgb` with red in bit 2.
- R7: The descriptor for cell (row, col) is read from word row*COLS+col. The glyph word is read from 0xE000 + 8*index + (line mod 8), with the index taken from descriptor bits 9:0 and the address wrapping at 16 bits.
- R8: Each word read is a request with `mem_hi`=0 followed on the next clock by a request with `mem_hi`=1 to the same `mem_addr`. `mem_rdata` is taken one clock after each request.
- R9: Every cell of every window line shows the data fetched for that cell. A fetch never overlaps another fetch or the reload of the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Byte read request |
| mem_hi | output | 1 | Byte select: 0 for bits 7:0, 1 for bits 15:8 |
| mem_addr | output | 16 | Word address of the request |
| mem_rdata | input | 8 | Byte returned on the clock after a request |
| pix_tick | output | 1 | One-clock pulse when a new pixel is presented |
| pix_rgb | output | 3 | Pixel colour, R in bit 2, G in bit 1, B in bit 0 |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The bench runs a reduced raster (4x2 cells inside a 96x20 visible area) through three whole frames, one for each memory pattern, and checks every pixel and both syncs against an arithmetic model. The first pattern gives every cell its own fixed glyph and a fixed colour pair. A swapped colour field or a reversed bit order stands out there. The second pattern is a hash that makes descriptors and glyph lines differ from cell to cell, which exposes byte-order, row-stride and line-offset errors. The third pattern forces the glyph indices to the top of the 10-bit range, so glyph addresses reach 0xFFFF and any truncation of the address arithmetic shows. A second instance running at the default fractional increment is counted over a 2048-clock window to confirm the enable rate.

// File: rtl/cellvid_pkg.sv
package cellvid_pkg;
  localparam int CELL_W  = 16;
  localparam int CELL_H  = 8;
  localparam int IDX_W   = 10;
  localparam int WADDR_W = 16;
  localparam int ACC_W   = 11;
  localparam int CNT_W   = 12;

  typedef struct packed {
    logic [2:0]       fg;
    logic [2:0]       bg;
    logic [IDX_W-1:0] idx;
  } cell_entry_t;

  typedef enum logic [2:0] {
    F_IDLE, F_TLO, F_THI, F_TCAP, F_GLO, F_GHI, F_GCAP
  } fetch_st_t;

  // word holding the descriptor of a cell
  function automatic logic [WADDR_W-1:0] table_word(input int row, input int col, input int cols);
    return WADDR_W'(row * cols + col);
  endfunction

  // word holding one line of a glyph
  function automatic logic [WADDR_W-1:0] glyph_word(input logic [WADDR_W-1:0] base,
                                                    input logic [IDX_W-1:0] idx,
                                                    input logic [2:0] line);
    return base + {3'b000, idx, 3'b000} + {13'b0, line};
  endfunction

  // true when v lies in [lo, lo+len)
  function automatic logic in_span(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction
endpackage

// File: rtl/cellvid_pxen.sv
module cellvid_pxen
  import cellvid_pkg::*;
#(
  parameter int INC = 776
) (
  input  logic clk,
  input  logic rst_n,
  output logic en
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(INC);
  assign en  = sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= sum[ACC_W-1:0];
  end

  // R2
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (acc_q < ACC_W'(INC)));
endmodule

// File: rtl/cellvid_timing.sv
module cellvid_timing
  import cellvid_pkg::*;
#(
  parameter int H_TOT = 800,
  parameter int V_TOT = 525
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] vcnt
);
  logic h_last, v_last;
  assign h_last = (hcnt == CNT_W'(H_TOT - 1));
  assign v_last = (vcnt == CNT_W'(V_TOT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_en) begin
      if (h_last) begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < CNT_W'(H_TOT));
  // R4
  vcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !h_last) |=> $stable(vcnt));
endmodule

// File: rtl/cellvid_fetch.sv
module cellvid_fetch
  import cellvid_pkg::*;
#(
  parameter int               COLS       = 32,
  parameter logic [WADDR_W-1:0] GLYPH_BASE = 16'hE000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   row,
  input  logic [CNT_W-1:0]   col,
  input  logic [2:0]         line,
  output logic               mem_rd,
  output logic               mem_hi,
  output logic [WADDR_W-1:0] mem_addr,
  input  logic [7:0]         mem_rdata,
  output logic               busy,
  output logic [CELL_W-1:0]  nxt_word,
  output logic [2:0]         nxt_fg,
  output logic [2:0]         nxt_bg
);
  fetch_st_t   st;
  logic [7:0]  lo_q;
  logic [2:0]  line_q, fg_p, bg_p;
  cell_entry_t ent;

  assign ent  = cell_entry_t'({mem_rdata, lo_q});
  assign busy = (st != F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= F_IDLE;
      mem_rd   <= 1'b0;
      mem_hi   <= 1'b0;
      mem_addr <= '0;
      lo_q     <= '0;
      line_q   <= '0;
      fg_p     <= '0;
      bg_p     <= '0;
      nxt_word <= '0;
      nxt_fg   <= '0;
      nxt_bg   <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          st       <= F_TLO;
          mem_rd   <= 1'b1;
          mem_hi   <= 1'b0;
          mem_addr <= table_word(int'(row), int'(col), COLS);
          line_q   <= line;
        end
        F_TLO: begin
          st     <= F_THI;
          mem_hi <= 1'b1;
        end
        F_THI: begin
          st     <= F_TCAP;
          mem_rd <= 1'b0;
          mem_hi <= 1'b0;
          lo_q   <= mem_rdata;
        end
        F_TCAP: begin
          st       <= F_GLO;
          mem_rd   <= 1'b1;
          mem_hi   <= 1'b0;
          mem_addr <= glyph_word(GLYPH_BASE, ent.idx, line_q);
          fg_p     <= ent.fg;
          bg_p     <= ent.bg;
        end
        F_GLO: begin
          st     <= F_GHI;
          mem_hi <= 1'b1;
        end
        F_GHI: begin
          st     <= F_GCAP;
          mem_rd <= 1'b0;
          mem_hi <= 1'b0;
          lo_q   <= mem_rdata;
        end
        F_GCAP: begin
          st       <= F_IDLE;
          nxt_word <= {mem_rdata, lo_q};
          nxt_fg   <= fg_p;
          nxt_bg   <= bg_p;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // R8
  byte_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_hi) |=> (mem_rd && mem_hi && $stable(mem_addr)));
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/cellvid_gen.sv
module cellvid_gen
  import cellvid_pkg::*;
#(
  parameter int PHASE_INC = 776,
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  parameter int COLS = 32,
  parameter int ROWS = 32,
  parameter logic [15:0] GLYPH_BASE = 16'hE000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_rd,
  output logic        mem_hi,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        pix_tick,
  output logic [2:0]  pix_rgb,
  output logic        hsync_n,
  output logic        vsync_n
);
  localparam int H_TOT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int PANE_W = COLS * CELL_W;
  localparam int PANE_H = ROWS * CELL_H;
  localparam int H_BRD  = (H_VIS - PANE_W) / 2;
  localparam int V_BRD  = (V_VIS - PANE_H) / 2;
  localparam int HS_BEG = H_VIS + H_FP;
  localparam int VS_BEG = V_VIS + V_FP;

  logic             pix_en;
  logic [CNT_W-1:0] hcnt, vcnt;

  cellvid_pxen #(.INC(PHASE_INC)) u_pxen (
    .clk(clk), .rst_n(rst_n), .en(pix_en)
  );

  cellvid_timing #(.H_TOT(H_TOT), .V_TOT(V_TOT)) u_timing (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hcnt(hcnt), .vcnt(vcnt)
  );

  // position decode, brought out as named events
  int   hpos, vpos, frel, lrel, vrel;
  logic h_in, v_in, in_pane, fetch_start, load_evt, fetch_busy;
  always_comb begin
    hpos = int'(hcnt);
    vpos = int'(vcnt);
    frel = hpos - (H_BRD - CELL_W);
    lrel = hpos - (H_BRD - 1);
    vrel = vpos - V_BRD;
  end
  assign h_in        = in_span(hpos, H_BRD, PANE_W);
  assign v_in        = in_span(vpos, V_BRD, PANE_H);
  assign in_pane     = h_in && v_in;
  assign fetch_start = pix_en && v_in && in_span(frel, 0, PANE_W) && (frel % CELL_W == 0);
  assign load_evt    = pix_en && v_in && in_span(lrel, 0, PANE_W) && (lrel % CELL_W == 0);

  logic [CNT_W-1:0]  f_row, f_col;
  logic [2:0]        f_line;
  logic [CELL_W-1:0] nxt_word;
  logic [2:0]        nxt_fg, nxt_bg;
  assign f_row  = CNT_W'(vrel / CELL_H);
  assign f_col  = CNT_W'(frel / CELL_W);
  assign f_line = 3'(vrel % CELL_H);

  cellvid_fetch #(.COLS(COLS), .GLYPH_BASE(GLYPH_BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(fetch_start),
    .row(f_row), .col(f_col), .line(f_line),
    .mem_rd(mem_rd), .mem_hi(mem_hi), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(fetch_busy), .nxt_word(nxt_word), .nxt_fg(nxt_fg), .nxt_bg(nxt_bg)
  );

  // shifter: loaded one pixel before its cell, bit 15 shown first
  logic [CELL_W-1:0] sh;
  logic [2:0]        cur_fg, cur_bg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cur_fg <= '0;
      cur_bg <= '0;
    end else if (load_evt) begin
      sh     <= nxt_word;
      cur_fg <= nxt_fg;
      cur_bg <= nxt_bg;
    end else if (pix_en && in_pane) begin
      sh <= {sh[CELL_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_tick <= 1'b0;
      pix_rgb  <= '0;
      hsync_n  <= 1'b1;
      vsync_n  <= 1'b1;
    end else begin
      pix_tick <= pix_en;
      if (pix_en) begin
        pix_rgb <= in_pane ? (sh[CELL_W-1] ? cur_fg : cur_bg) : 3'b000;
        hsync_n <= !in_span(hpos, HS_BEG, H_SYNC);
        vsync_n <= !in_span(vpos, VS_BEG, V_SYNC);
      end
    end
  end

  // R9
  load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !fetch_busy);
endmodule

// File: tb/cellvid_gen_bench.sv
module cellvid_gen_bench;
  localparam int COLS = 4, ROWS = 2;
  localparam int H_VIS = 96, H_FP = 4, H_SYNC = 8, H_BP = 4;
  localparam int V_VIS = 20, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HB = (H_VIS - COLS * 16) / 2;
  localparam int VB = (V_VIS - ROWS * 8) / 2;
  localparam int INC_A = 1024, INC_B = 776;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int pat = 0, frames = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory contents are computed, never stored
  function automatic logic [15:0] word_at(input logic [15:0] a, input int p);
    logic [15:0] h;
    h = (a * 16'h9E37) ^ {a[7:0], a[15:8]} ^ 16'(p * 7919);
    if (p == 0) h = (a < 16'd1024) ? {3'b110, 3'b001, a[9:0]} : (16'hC3A5 ^ a);
    if (p == 2 && a < 16'd1024) h[9:0] = 10'h3FF - 10'(a & 16'd3);
    return h;
  endfunction

  function automatic logic [2:0] exp_rgb(input int h, input int v, input int p);
    int x, y;
    logic [15:0] ent, g;
    if (h < HB || h >= HB + COLS * 16 || v < VB || v >= VB + ROWS * 8) return 3'b000;
    x = h - HB;
    y = v - VB;
    ent = word_at(16'((y / 8) * COLS + x / 16), p);
    g = word_at(16'hE000 + {3'b000, ent[9:0], 3'b000} + 16'(y % 8), p);
    return g[15 - (x % 16)] ? ent[15:13] : ent[12:10];
  endfunction

  // instance A: half-rate pixels, full frame checking
  logic rd_a, hi_a, tick_a, hs_a, vs_a;
  logic [15:0] addr_a, w_a;
  logic [7:0] rdata_a;
  logic [2:0] rgb_a;
  assign w_a = word_at(addr_a, pat);
  always @(posedge clk) if (rd_a) rdata_a <= hi_a ? w_a[15:8] : w_a[7:0];

  cellvid_gen #(.PHASE_INC(INC_A), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .COLS(COLS), .ROWS(ROWS))
  u_cellvid_gen (
    .clk(clk), .rst_n(rst_n), .mem_rd(rd_a), .mem_hi(hi_a), .mem_addr(addr_a),
    .mem_rdata(rdata_a), .pix_tick(tick_a), .pix_rgb(rgb_a), .hsync_n(hs_a), .vsync_n(vs_a)
  );

  // instance B: default fractional increment, rate only
  logic rd_b, hi_b, tick_b, hs_b, vs_b;
  logic [15:0] addr_b, w_b;
  logic [7:0] rdata_b;
  logic [2:0] rgb_b;
  assign w_b = word_at(addr_b, 1);
  always @(posedge clk) if (rd_b) rdata_b <= hi_b ? w_b[15:8] : w_b[7:0];

  cellvid_gen #(.PHASE_INC(INC_B), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .COLS(COLS), .ROWS(ROWS))
  u_rate (
    .clk(clk), .rst_n(rst_n), .mem_rd(rd_b), .mem_hi(hi_b), .mem_addr(addr_b),
    .mem_rdata(rdata_b), .pix_tick(tick_b), .pix_rgb(rgb_b), .hsync_n(hs_b), .vsync_n(vs_b)
  );

  // pixel and sync model
  int eh = 0, ev = 0;
  always @(negedge clk) begin
    if (rst_n && tick_a && frames < 3) begin
      logic [2:0] e;
      logic hx, vx;
      e  = exp_rgb(eh, ev, pat);
      hx = !(eh >= H_VIS + H_FP && eh < H_VIS + H_FP + H_SYNC);
      vx = !(ev >= V_VIS + V_FP && ev < V_VIS + V_FP + V_SYNC);
      if (eh >= HB && eh < HB + COLS * 16 && ev >= VB && ev < VB + ROWS * 8)
        chk(rgb_a == e, "R6 cell pixel", int'(rgb_a), int'(e));
      else
        chk(rgb_a == e, "R5 border black", int'(rgb_a), int'(e));
      chk(hs_a == hx, "R3 hsync", int'(hs_a), int'(hx));
      chk(vs_a == vx, "R4 vsync", int'(vs_a), int'(vx));
      eh++;
      if (eh == H_TOT) begin
        eh = 0;
        ev++;
        if (ev == V_TOT) begin
          ev = 0;
          frames++;
          pat = frames;
        end
      end
    end
  end

  // memory port protocol
  logic prev_lo = 1'b0;
  logic [15:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n && frames < 3) begin
      if (prev_lo) begin
        chk(rd_a && hi_a, "R8 high byte follows low", int'({rd_a, hi_a}), 3);
        chk(addr_a == prev_addr, "R8 same word", int'(addr_a), int'(prev_addr));
      end
      if (rd_a && !hi_a)
        chk(addr_a < 16'(COLS * ROWS) || addr_a >= 16'hE000, "R7 address region",
            int'(addr_a), 16'hE000);
      prev_lo   = rd_a && !hi_a;
      prev_addr = addr_a;
    end
  end

  // enable-rate windows
  int cyc = 0, cnt_a = 0, cnt_b = 0;
  bit rate_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !rate_done) begin
      cyc++;
      if (cyc > 100 && cyc <= 100 + 2048) begin
        cnt_a += int'(tick_a);
        cnt_b += int'(tick_b);
      end
      if (cyc == 100 + 2048) begin
        chk(cnt_a == INC_A, "R2 enable rate half", cnt_a, INC_A);
        chk(cnt_b == INC_B, "R2 enable rate fractional", cnt_b, INC_B);
        rate_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tick_a && !rd_a, "R1 idle in reset", int'({tick_a, rd_a}), 0);
    chk(rgb_a == 3'b000, "R1 black in reset", int'(rgb_a), 0);
    chk(hs_a && vs_a, "R1 syncs high in reset", int'({hs_a, vs_a}), 3);
    rst_n = 1'b1;
    for (int i = 0; i < 40000 && !(frames >= 3 && rate_done); i++) @(posedge clk);
    if (!(frames >= 3 && rate_done)) chk(1'b0, "R9 watchdog expired", frames, 3);
    chk(frames == 3, "R9 frames completed", frames, 3);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule